// File: doc/BRIEF.md
# Quarter-Duty Half-Bias LCD Scan Driver

This block scans a multiplexed liquid-crystal panel with four common electrodes and a parameterized number of segment electrodes (19 by default). A reference clock is divided down to a common-phase tick. Four phases make one frame, and with the default parameters the frame rate is 75 Hz. In each phase one common is selected and driven to a full rail. The other three commons rest at the mid level, which is what half bias calls for. Every segment is driven to one of the two rails. A segment takes the rail opposite the selected common when its pixel for that common is on, and the same rail when the pixel is off. The drive polarity flips on every frame, so the average voltage across each pixel over two frames is zero.

Drive levels leave the block as digital codes. The pad circuitry turns each code into an analog voltage. Pixel data is written one segment at a time through a simple write port into a shadow bank. The visible bank takes the shadow contents only at the start of a phase, so a write can never change the waveform partway through a phase. Reset and the backup input both force every output to the low code.

Top module: `lcd_quarter_drive`

## Requirements
- R1: Each common phase lasts exactly PHASE_DIV = REF_HZ/(FRAME_HZ*4) clock cycles. The phases run in the order 0,1,2,3, and the selected common index equals the phase number. The first phase starts on the first clock edge after reset or backup is released.
- R2: While running, exactly one common carries a rail code. The three others carry the mid code 2'b01. Common i uses bits com_o[2i+1:2i].
- R3: The selected common is driven high (code 2'b10) in the first frame after start and low (code 2'b00) in the next frame, and the polarity alternates on every frame after that.
- R4: Segment j (seg_o[j], 1 = high, 0 = low) takes the rail opposite the selected common during phase k when bit k of its stored nibble is 1. It takes the same rail as the selected common when that bit is 0.
- R5: A write with wr_en_i high stores wr_bits_i for segment wr_idx_i. The new data becomes visible only at the next phase start that follows the capturing edge. A write captured on the very edge that starts a phase waits for the phase start after that one.
- R6: A write whose index is NUM_SEG or above is ignored and changes no segment.
- R7: While reset is asserted, every common code is 2'b00 and every segment is 0. Reset clears all stored pixel data.
- R8: From the first clock edge with backup_i high, every common code is 2'b00 and every segment is 0. Writes are still accepted into the shadow bank during backup. When backup is released, scanning restarts at phase 0 with high polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| backup_i | input | 1 | Backup request; forces the outputs low and holds the scan |
| wr_en_i | input | 1 | Pixel write strobe |
| wr_idx_i | input | IW | Segment index for the write |
| wr_bits_i | input | 4 | One bit per common (bit k belongs to common k) |
| com_o | output | 8 | Four 2-bit common drive codes (00 low, 01 mid, 10 high) |
| seg_o | output | NUM_SEG | Segment rail levels |

## Verification
A wrong phase counter or divider makes the selected common move at the wrong edge. That shows on com_o within one phase of the fault. A stuck polarity bit shows as a missing low-rail frame after 4*PHASE_DIV cycles. A wrong commit time shows as segment data changing partway through a phase, or one phase too early. A write that lands in the wrong slot shows on some segment during the phase that reads the affected bit. Scanning every phase of two full frames therefore exposes any such fault within 8*PHASE_DIV cycles.

// File: rtl/lcd_qd_pkg.sv
package lcd_qd_pkg;

    localparam int unsigned NUM_COM = 4;

    typedef enum logic [1:0] {
        DRV_LOW  = 2'b00,
        DRV_MID  = 2'b01,
        DRV_HIGH = 2'b10
    } drv_e;

    // Common code: selected commons go to the rail of the current polarity.
    function automatic logic [1:0] com_code(input logic sel, input logic pol);
        drv_e c;
        if (!sel)
            c = DRV_MID;
        else if (pol)
            c = DRV_LOW;
        else
            c = DRV_HIGH;
        return c;
    endfunction

    // Segment rail: opposite of the selected common when lit, equal otherwise.
    function automatic logic seg_level(input logic lit, input logic pol);
        return lit ? pol : ~pol;
    endfunction

endpackage

// File: rtl/lcd_qd_timing.sv
module lcd_qd_timing #(
    parameter int unsigned PHASE_DIV = 256
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       hold_i,
    output logic [1:0] phase_nx_o,
    output logic       pol_nx_o,
    output logic       run_nx_o,
    output logic       commit_o
);

    localparam int unsigned CW = (PHASE_DIV > 1) ? $clog2(PHASE_DIV) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [1:0]    phase;
        logic          pol;
        logic          run;
    } tim_t;

    tim_t st_q, st_d;
    logic commit_d;

    always_comb begin
        st_d     = st_q;
        commit_d = 1'b0;
        if (hold_i) begin
            st_d = '0;
        end else if (!st_q.run) begin
            st_d     = '0;
            st_d.run = 1'b1;
        end else if (st_q.cnt == CNT_LAST) begin
            st_d.cnt   = '0;
            st_d.phase = st_q.phase + 2'd1;
            if (st_q.phase == 2'd3)
                st_d.pol = ~st_q.pol;
            commit_d   = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign phase_nx_o = st_d.phase;
    assign pol_nx_o   = st_d.pol;
    assign run_nx_o   = st_d.run;
    assign commit_o   = commit_d;

endmodule

// File: rtl/lcd_qd_segram.sv
module lcd_qd_segram #(
    parameter int unsigned NUM_SEG = 19,
    parameter int unsigned IW      = 5
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 wr_en_i,
    input  logic [IW-1:0]        wr_idx_i,
    input  logic [3:0]           wr_bits_i,
    input  logic                 commit_i,
    output logic [NUM_SEG*4-1:0] act_nx_o
);

    typedef logic [NUM_SEG-1:0][3:0] bank_t;

    typedef struct packed {
        bank_t shadow;
        bank_t act;
    } ram_t;

    ram_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (commit_i)
            st_d.act = st_q.shadow;
        if (wr_en_i) begin
            for (int j = 0; j < int'(NUM_SEG); j++) begin
                if (wr_idx_i == IW'(j))
                    st_d.shadow[j] = wr_bits_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign act_nx_o = st_d.act;

endmodule

// File: rtl/lcd_qd_wave.sv
module lcd_qd_wave
    import lcd_qd_pkg::*;
#(
    parameter int unsigned NUM_SEG = 19
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [1:0]             phase_i,
    input  logic                   pol_i,
    input  logic                   run_i,
    input  logic [NUM_SEG*4-1:0]   act_i,
    output logic [2*NUM_COM-1:0]   com_o,
    output logic [NUM_SEG-1:0]     seg_o
);

    typedef struct packed {
        logic [2*NUM_COM-1:0] com;
        logic [NUM_SEG-1:0]   seg;
    } out_t;

    out_t st_q, st_d;
    logic [2*NUM_COM-1:0] com_w;
    logic [NUM_SEG-1:0]   seg_w;

    for (genvar c = 0; c < int'(NUM_COM); c++) begin : g_com
        assign com_w[2*c +: 2] = com_code(phase_i == 2'(c), pol_i);
    end

    for (genvar j = 0; j < int'(NUM_SEG); j++) begin : g_seg
        logic [3:0] nib;
        assign nib      = act_i[4*j +: 4];
        assign seg_w[j] = seg_level(nib[phase_i], pol_i);
    end

    always_comb begin
        st_d = '0;
        if (run_i) begin
            st_d.com = com_w;
            st_d.seg = seg_w;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign com_o = st_q.com;
    assign seg_o = st_q.seg;

endmodule

// File: rtl/lcd_quarter_drive.sv
module lcd_quarter_drive #(
    parameter int unsigned NUM_SEG  = 19,
    parameter int unsigned REF_HZ   = 76800,
    parameter int unsigned FRAME_HZ = 75,
    parameter int unsigned IW       = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               backup_i,
    input  logic               wr_en_i,
    input  logic [IW-1:0]      wr_idx_i,
    input  logic [3:0]         wr_bits_i,
    output logic [7:0]         com_o,
    output logic [NUM_SEG-1:0] seg_o
);

    localparam int unsigned PHASE_DIV = REF_HZ / (FRAME_HZ * 4);

    logic [1:0]           phase_nx;
    logic                 pol_nx;
    logic                 run_nx;
    logic                 commit;
    logic [NUM_SEG*4-1:0] act_nx;

    lcd_qd_timing #(.PHASE_DIV(PHASE_DIV)) u_timing (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .hold_i     (backup_i),
        .phase_nx_o (phase_nx),
        .pol_nx_o   (pol_nx),
        .run_nx_o   (run_nx),
        .commit_o   (commit)
    );

    lcd_qd_segram #(.NUM_SEG(NUM_SEG), .IW(IW)) u_segram (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_idx_i  (wr_idx_i),
        .wr_bits_i (wr_bits_i),
        .commit_i  (commit),
        .act_nx_o  (act_nx)
    );

    lcd_qd_wave #(.NUM_SEG(NUM_SEG)) u_wave (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .phase_i (phase_nx),
        .pol_i   (pol_nx),
        .run_i   (run_nx),
        .act_i   (act_nx),
        .com_o   (com_o),
        .seg_o   (seg_o)
    );

endmodule

// File: rtl/lcd_qd_chk.sv
module lcd_qd_chk #(
    parameter int unsigned NUM_SEG = 19
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               backup_i,
    input logic               commit,
    input logic [7:0]         com_o,
    input logic [NUM_SEG-1:0] seg_o
);

    logic [3:0] rail_mask;
    logic [1:0] sel_idx;
    logic       sel_low;
    logic       running;

    always_comb begin
        sel_idx = 2'd0;
        sel_low = 1'b0;
        for (int c = 0; c < 4; c++) begin
            rail_mask[c] = (com_o[2*c +: 2] != 2'b01);
            if (rail_mask[c]) begin
                sel_idx = 2'(c);
                sel_low = (com_o[2*c +: 2] == 2'b00);
            end
        end
    end

    assign running = (com_o != 8'h00);

    // R7: outputs low while reset is held
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            a_r7_reset_low: assert (com_o == 8'h00 && seg_o == '0);
        end
    end

    // R2: one rail common while scanning
    a_r2_single_rail: assert property (@(posedge clk_i) disable iff (!rst_ni)
        running |-> $countones(rail_mask) == 1);

    // R1: the selected common advances by one at each phase start
    a_r1_phase_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running && commit && !backup_i) |=> sel_idx == $past(sel_idx) + 2'd1);

    // R3: polarity flips when phase 3 hands over to phase 0
    a_r3_pol_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running && commit && !backup_i && sel_idx == 2'd3) |=> sel_low != $past(sel_low));

    // R5: nothing moves inside a phase
    a_r5_steady_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (running && !commit && !backup_i) |=> ($stable(seg_o) && $stable(com_o)));

    // R8: backup forces low at the next edge
    a_r8_backup_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        backup_i |=> (com_o == 8'h00 && seg_o == '0));

endmodule

bind lcd_quarter_drive lcd_qd_chk #(.NUM_SEG(NUM_SEG)) u_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .backup_i (backup_i),
    .commit   (commit),
    .com_o    (com_o),
    .seg_o    (seg_o)
);

// File: tb/lcd_quarter_drive_tb_top.sv
module lcd_quarter_drive_tb_top;

    localparam int NS = 19;
    localparam int D  = 8;   // 2400 / (75*4)

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bk = 1'b0;
    logic          wr_en = 1'b0;
    logic [4:0]    wr_idx = '0;
    logic [3:0]    wr_bits = '0;
    logic [7:0]    com;
    logic [NS-1:0] seg;

    int n_chk = 0;
    int n_fail = 0;
    int t = 0;
    bit done = 1'b0;
    logic [3:0] m_sh  [NS];
    logic [3:0] m_act [NS];

    always #10 clk = ~clk;

    lcd_quarter_drive #(.NUM_SEG(NS), .REF_HZ(2400), .FRAME_HZ(75)) dut_i (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .backup_i  (bk),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_bits_i (wr_bits),
        .com_o     (com),
        .seg_o     (seg)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            if (!rst_n) begin
                t = 0;
                for (int j = 0; j < NS; j++) begin m_sh[j] = '0; m_act[j] = '0; end
            end else begin
                if (bk) t = 0;
                else begin
                    t++;
                    if (t > 1 && (t - 1) % D == 0)
                        for (int j = 0; j < NS; j++) m_act[j] = m_sh[j];
                end
                if (wr_en && int'(wr_idx) < NS) m_sh[wr_idx] = wr_bits;
            end
            @(negedge clk);
            wr_en = 1'b0;
        end
    endtask

    task automatic go_to(input int target);
        if (target > t) tick(target - t);
    endtask

    task automatic chk(input string req);
        logic [7:0]    ec;
        logic [NS-1:0] es;
        int ph, pl;
        ec = '0; es = '0;
        if (t > 0) begin
            ph = ((t - 1) / D) % 4;
            pl = ((t - 1) / (4 * D)) % 2;
            for (int c = 0; c < 4; c++)
                ec[2*c +: 2] = (c == ph) ? (pl == 1 ? 2'b00 : 2'b10) : 2'b01;
            for (int j = 0; j < NS; j++)
                es[j] = m_act[j][ph] ? (pl == 1) : (pl == 0);
        end
        n_chk++;
        if (com !== ec || seg !== es) begin
            n_fail++;
            $display("FAIL %s t=%0d com=%h exp=%h seg=%h exp=%h", req, t, com, ec, seg, es);
        end
    endtask

    task automatic do_write(input int idx, input logic [3:0] bits);
        wr_en = 1'b1; wr_idx = 5'(idx); wr_bits = bits;
        tick(1);
    endtask

    task automatic next_mid();
        go_to(((t - 1) / D + 1) * D + 1 + D / 2);
    endtask

    task automatic scan(input string req);
        for (int k = 0; k < 8; k++) begin
            next_mid();
            chk(req);
        end
    endtask

    task automatic t_reset();
        tick(3);
        chk("R7");
        rst_n = 1'b1;
        tick(1);
        chk("R7");
    endtask

    task automatic t_period();
        go_to(D);          chk("R1");
        go_to(D + 1);      chk("R1");
        go_to(4 * D);      chk("R3");
        go_to(4 * D + 1);  chk("R3");
        scan("R2");
    endtask

    task automatic t_patterns();
        for (int j = 0; j < NS; j++) do_write(j, 4'((j * 5 + 3) % 16));
        scan("R4");
    endtask

    task automatic t_defer();
        next_mid();
        do_write(2, ~m_sh[2]);
        chk("R5");
        go_to(((t - 1) / D + 1) * D);
        chk("R5");
        tick(1);
        chk("R5");
        go_to(((t - 1) / D + 1) * D);
        do_write(5, ~m_sh[5]);
        chk("R5");
        scan("R5");
    endtask

    task automatic t_range();
        do_write(19, 4'hF);
        do_write(31, 4'h5);
        do_write(3, 4'h0);
        scan("R6");
    endtask

    task automatic t_backup();
        next_mid();
        bk = 1'b1;
        tick(1);
        chk("R8");
        do_write(0, 4'h9);
        tick(3);
        chk("R8");
        bk = 1'b0;
        tick(1);
        chk("R8");
        scan("R8");
    endtask

    initial begin
        for (int j = 0; j < NS; j++) begin m_sh[j] = '0; m_act[j] = '0; end
        @(negedge clk);
        t_reset();
        t_period();
        t_patterns();
        t_defer();
        t_range();
        t_backup();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired t=%0d", t);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

endmodule